// File: doc/BRIEF.md
# Multifunction Status Output Selector

This block drives the single shared status pin of a two-synthesizer frequency source. Each synthesizer's reference latch holds two mode bits: a lock-select bit and an output-select bit. The four bits together pick what the pin carries. The choices are a lock indication, a reference-divider or programmable-divider pulse train, or a driven-low idle level. Two codes are not signal selections at all. One asks the loop filter to switch in its fastlock damping path. The other holds every divider counter in reset.

The four mode bits are registered into a decoded mode, so a latch update takes effect at the next clock edge. The selected data inputs then pass combinationally to the pin with no added delay. Lock indications keep their narrow low pulses. Codes that are reserved drive the pin low and set a sticky flag that only reset clears.

Top module: `fold_sel`

## Requirements
- R1: While rst_ni is low and afterwards until a mode is loaded, pin_o is 0, pin_oe_o is 1, and fastlock_o, cnt_rst_o and illegal_o are 0.
- R2: The mode code is {sy1_lk_sel_i, sy2_lk_sel_i, sy1_fo_sel_i, sy2_fo_sel_i} (bit 3 down to bit 0). Code 0000 drives pin_o low with pin_oe_o high.
- R3: Code 0100 puts sy2_lock_i on pin_o and code 1000 puts sy1_lock_i on it. Code 1100 puts sy1_lock_i AND sy2_lock_i on it, so the pin is high only when both synthesizers are locked. Narrow low pulses on a lock input reach the pin unfiltered. pin_oe_o is 1 in all three codes.
- R4: With output-select bits 01, pin_o carries sy2_ref_i when bit 2 is 0 and sy2_prg_i when bit 2 is 1. With output-select bits 10, pin_o carries sy1_ref_i when bit 2 is 0 and sy1_prg_i when bit 2 is 1. Bit 3 is ignored in both cases and pin_oe_o is 1.
- R5: Code 0011 is fastlock. fastlock_o and pin_oe_o equal sy1_cp_hi_i OR sy2_cp_hi_i, and pin_o is 0, so the pin pulls the damping path to ground only while a charge-pump current bit is high.
- R6: Code 1111 raises cnt_rst_o for as long as it is held, with pin_o 0 and pin_oe_o 1. cnt_rst_o falls at the first edge after the code is removed. In every other code cnt_rst_o is 0.
- R7: Reserved codes 0111 and 1011 drive pin_o 0 with pin_oe_o 1, and keep fastlock_o and cnt_rst_o at 0.
- R8: illegal_o rises at the same edge a reserved code takes effect. It stays high through any later legal code until rst_ni is asserted.
- R9: A change of the mode bits shows on the outputs only after the next rising clock edge. A change of a data input shows on pin_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sy1_lk_sel_i | input | 1 | Synthesizer-1 lock-select mode bit (code bit 3) |
| sy2_lk_sel_i | input | 1 | Synthesizer-2 lock-select mode bit (code bit 2) |
| sy1_fo_sel_i | input | 1 | Synthesizer-1 output-select mode bit (code bit 1) |
| sy2_fo_sel_i | input | 1 | Synthesizer-2 output-select mode bit (code bit 0) |
| sy1_lock_i | input | 1 | Synthesizer-1 lock indication |
| sy2_lock_i | input | 1 | Synthesizer-2 lock indication |
| sy1_ref_i | input | 1 | Synthesizer-1 reference-divider output |
| sy2_ref_i | input | 1 | Synthesizer-2 reference-divider output |
| sy1_prg_i | input | 1 | Synthesizer-1 programmable-divider output |
| sy2_prg_i | input | 1 | Synthesizer-2 programmable-divider output |
| sy1_cp_hi_i | input | 1 | Synthesizer-1 charge-pump high-current bit |
| sy2_cp_hi_i | input | 1 | Synthesizer-2 charge-pump high-current bit |
| pin_o | output | 1 | Status pin value |
| pin_oe_o | output | 1 | Status pin output enable |
| fastlock_o | output | 1 | Fastlock damping switch request |
| cnt_rst_o | output | 1 | Hold-all-counters-in-reset command |
| illegal_o | output | 1 | Sticky reserved-mode flag |

## Verification
The mode register and the illegal flag update on the first rising edge after new mode bits are driven. The data inputs reach pin_o with no clock in between. The bench therefore drives mode bits and data at the falling edge and samples every output one nanosecond after the next rising edge. It compares them there with a model evaluated on that same code and data. For the latency requirement it also samples right after the falling-edge drive, before the edge, and expects the old mode's values. Illegal-flag persistence is checked by applying legal codes after a reserved one, then again after a fresh reset.

// File: rtl/fold_pkg.sv
package fold_pkg;

  localparam int unsigned CODE_W = 4;

  // code bit order: {sy1_lk, sy2_lk, sy1_fo, sy2_fo}
  localparam int unsigned B_LK1 = 3;
  localparam int unsigned B_LK2 = 2;

  typedef enum logic [3:0] {
    FM_OFF,
    FM_LK2,
    FM_LK1,
    FM_LKB,
    FM_REF2,
    FM_PRG2,
    FM_REF1,
    FM_PRG1,
    FM_FAST,
    FM_RSVD,
    FM_CRST
  } fold_mode_e;

  typedef struct packed {
    logic pin;
    logic oe;
    logic fast;
    logic crst;
  } fold_out_t;

  function automatic fold_mode_e fold_decode(input logic [CODE_W-1:0] c);
    fold_mode_e m;
    case (c[1:0])
      2'b00: begin
        case (c[B_LK1:B_LK2])
          2'b00:   m = FM_OFF;
          2'b01:   m = FM_LK2;
          2'b10:   m = FM_LK1;
          default: m = FM_LKB;
        endcase
      end
      2'b01:   m = c[B_LK2] ? FM_PRG2 : FM_REF2;
      2'b10:   m = c[B_LK2] ? FM_PRG1 : FM_REF1;
      default: begin
        case (c[B_LK1:B_LK2])
          2'b00:   m = FM_FAST;
          2'b11:   m = FM_CRST;
          default: m = FM_RSVD;
        endcase
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fold_mode_reg.sv
module fold_mode_reg
  import fold_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output fold_mode_e        mode_o
);

  fold_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= FM_OFF;
    else         mode_q <= fold_decode(code_i);
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/fold_illegal_trk.sv
module fold_illegal_trk
  import fold_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              illegal_o
);

  logic ill_q;
  logic hit;

  assign hit = (fold_decode(code_i) == FM_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ill_q <= 1'b0;
    else if (hit) ill_q <= 1'b1;
  end

  assign illegal_o = ill_q;

endmodule

// File: rtl/fold_out_mux.sv
module fold_out_mux
  import fold_pkg::*;
(
  input  fold_mode_e mode_i,
  input  logic [1:0] lock_i,
  input  logic [1:0] ref_i,
  input  logic [1:0] prg_i,
  input  logic [1:0] cp_hi_i,
  output fold_out_t  out_o
);

  logic cp_any;
  assign cp_any = |cp_hi_i;

  // index 0 = synthesizer 1, index 1 = synthesizer 2
  always_comb begin
    out_o = '{pin: 1'b0, oe: 1'b1, fast: 1'b0, crst: 1'b0};
    case (mode_i)
      FM_LK2:  out_o.pin = lock_i[1];
      FM_LK1:  out_o.pin = lock_i[0];
      FM_LKB:  out_o.pin = &lock_i;
      FM_REF2: out_o.pin = ref_i[1];
      FM_PRG2: out_o.pin = prg_i[1];
      FM_REF1: out_o.pin = ref_i[0];
      FM_PRG1: out_o.pin = prg_i[0];
      FM_FAST: begin
        out_o.oe   = cp_any;
        out_o.fast = cp_any;
      end
      FM_CRST: out_o.crst = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/fold_sel.sv
module fold_sel
  import fold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sy1_lk_sel_i,
  input  logic sy2_lk_sel_i,
  input  logic sy1_fo_sel_i,
  input  logic sy2_fo_sel_i,
  input  logic sy1_lock_i,
  input  logic sy2_lock_i,
  input  logic sy1_ref_i,
  input  logic sy2_ref_i,
  input  logic sy1_prg_i,
  input  logic sy2_prg_i,
  input  logic sy1_cp_hi_i,
  input  logic sy2_cp_hi_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic fastlock_o,
  output logic cnt_rst_o,
  output logic illegal_o
);

  logic [CODE_W-1:0] code;
  fold_mode_e        mode;
  fold_out_t         out;

  assign code = {sy1_lk_sel_i, sy2_lk_sel_i, sy1_fo_sel_i, sy2_fo_sel_i};

  fold_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (code),
    .mode_o (mode)
  );

  fold_illegal_trk u_ill (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code),
    .illegal_o (illegal_o)
  );

  fold_out_mux u_mux (
    .mode_i  (mode),
    .lock_i  ({sy2_lock_i, sy1_lock_i}),
    .ref_i   ({sy2_ref_i, sy1_ref_i}),
    .prg_i   ({sy2_prg_i, sy1_prg_i}),
    .cp_hi_i ({sy2_cp_hi_i, sy1_cp_hi_i}),
    .out_o   (out)
  );

  assign pin_o      = out.pin;
  assign pin_oe_o   = out.oe;
  assign fastlock_o = out.fast;
  assign cnt_rst_o  = out.crst;

endmodule

// File: rtl/fold_sel_chk.sv
module fold_sel_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sy1_lk_sel_i,
  input logic sy2_lk_sel_i,
  input logic sy1_fo_sel_i,
  input logic sy2_fo_sel_i,
  input logic sy1_lock_i,
  input logic sy2_lock_i,
  input logic sy1_cp_hi_i,
  input logic sy2_cp_hi_i,
  input logic pin_o,
  input logic pin_oe_o,
  input logic fastlock_o,
  input logic cnt_rst_o,
  input logic illegal_o
);

  logic [3:0] code;
  logic       past_ok;

  assign code = {sy1_lk_sel_i, sy2_lk_sel_i, sy1_fo_sel_i, sy2_fo_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_ok |-> (pin_oe_o && !pin_o && !fastlock_o && !cnt_rst_o && !illegal_o));

  // R2
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(code) == 4'b0000) |-> (pin_oe_o && !pin_o));

  // R3
  both_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(code) == 4'b1100) |-> (pin_o == (sy1_lock_i && sy2_lock_i)));

  // R5
  fastlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(code) == 4'b0011) |->
      (fastlock_o == (sy1_cp_hi_i || sy2_cp_hi_i) && !pin_o));

  // R6
  cnt_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (cnt_rst_o == ($past(code) == 4'b1111)));

  // R7
  reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ($past(code) == 4'b0111 || $past(code) == 4'b1011)) |->
      (pin_oe_o && !pin_o && !fastlock_o && !cnt_rst_o && illegal_o));

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(illegal_o)) |-> illegal_o);

  // R9
  fast_only_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fastlock_o |-> (past_ok && $past(code) == 4'b0011));

endmodule

bind fold_sel fold_sel_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sy1_lk_sel_i (sy1_lk_sel_i),
  .sy2_lk_sel_i (sy2_lk_sel_i),
  .sy1_fo_sel_i (sy1_fo_sel_i),
  .sy2_fo_sel_i (sy2_fo_sel_i),
  .sy1_lock_i   (sy1_lock_i),
  .sy2_lock_i   (sy2_lock_i),
  .sy1_cp_hi_i  (sy1_cp_hi_i),
  .sy2_cp_hi_i  (sy2_cp_hi_i),
  .pin_o        (pin_o),
  .pin_oe_o     (pin_oe_o),
  .fastlock_o   (fastlock_o),
  .cnt_rst_o    (cnt_rst_o),
  .illegal_o    (illegal_o)
);

// File: tb/fold_sel_tb.sv
`timescale 1ns/1ps
module fold_sel_tb;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] code = 4'b0000;
  // {cp2, cp1, prg2, prg1, ref2, ref1, lock2, lock1}
  logic [7:0] dat = 8'h00;
  logic pin_o, pin_oe_o, fastlock_o, cnt_rst_o, illegal_o;

  int checks = 0;
  int errors = 0;
  logic exp_ill = 1'b0;

  always #2 clk = ~clk;

  fold_sel u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sy1_lk_sel_i (code[3]),
    .sy2_lk_sel_i (code[2]),
    .sy1_fo_sel_i (code[1]),
    .sy2_fo_sel_i (code[0]),
    .sy1_lock_i   (dat[0]),
    .sy2_lock_i   (dat[1]),
    .sy1_ref_i    (dat[2]),
    .sy2_ref_i    (dat[3]),
    .sy1_prg_i    (dat[4]),
    .sy2_prg_i    (dat[5]),
    .sy1_cp_hi_i  (dat[6]),
    .sy2_cp_hi_i  (dat[7]),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o),
    .fastlock_o   (fastlock_o),
    .cnt_rst_o    (cnt_rst_o),
    .illegal_o    (illegal_o)
  );

  // returns {pin, oe, fast, crst}
  function automatic logic [3:0] model(input logic [3:0] c, input logic [7:0] d);
    logic cp;
    cp = d[6] | d[7];
    case (c)
      4'b0000: return 4'b0100;
      4'b0100: return {d[1], 3'b100};
      4'b1000: return {d[0], 3'b100};
      4'b1100: return {d[0] & d[1], 3'b100};
      4'b0001, 4'b1001: return {d[3], 3'b100};
      4'b0101, 4'b1101: return {d[5], 3'b100};
      4'b0010, 4'b1010: return {d[2], 3'b100};
      4'b0110, 4'b1110: return {d[4], 3'b100};
      4'b0011: return {1'b0, cp, cp, 1'b0};
      4'b1111: return 4'b0101;
      default: return 4'b0100;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R2";
      4'b0100, 4'b1000, 4'b1100: return "R3";
      4'b0011: return "R5";
      4'b1111: return "R6";
      4'b0111, 4'b1011: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic cmp(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pin,oe,fast,crst,ill} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {pin_o, pin_oe_o, fastlock_o, cnt_rst_o, illegal_o};
  endfunction

  // drive at falling edge, check just after the following rising edge
  task automatic step(input logic [3:0] c, input logic [7:0] d, input string req);
    @(negedge clk);
    code = c;
    dat  = d;
    if (c == 4'b0111 || c == 4'b1011) exp_ill = 1'b1;
    @(posedge clk);
    #1;
    cmp(req, outs(), {model(c, d), exp_ill});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    code   = 4'b0000;
    exp_ill = 1'b0;
    #1;
    cmp("R1", outs(), 5'b01000);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    cmp("R1", outs(), 5'b01000);
  endtask

  initial begin
    void'($urandom(32'h5eed_f01d));
    do_reset();

    step(4'b0000, 8'hff, "R2");
    // lock selections, including a narrow low pulse on one lock input
    for (int i = 0; i < 4; i++) begin
      step(4'b0100, 8'(i), "R3");
      step(4'b1000, 8'(i), "R3");
      step(4'b1100, 8'(i), "R3");
    end
    step(4'b1100, 8'h03, "R3");
    @(negedge clk); dat = 8'h01; #1;
    cmp("R3", outs(), {model(4'b1100, 8'h01), exp_ill});
    @(negedge clk); dat = 8'h03; #1;
    cmp("R3", outs(), {model(4'b1100, 8'h03), exp_ill});

    // divider selections, bit 3 ignored
    step(4'b0001, 8'h08, "R4");
    step(4'b1001, 8'h37, "R4");
    step(4'b0101, 8'h20, "R4");
    step(4'b1101, 8'h1f, "R4");
    step(4'b0010, 8'h04, "R4");
    step(4'b1010, 8'h3b, "R4");
    step(4'b0110, 8'h10, "R4");
    step(4'b1110, 8'h2f, "R4");

    // fastlock with each charge-pump combination
    step(4'b0011, 8'h00, "R5");
    step(4'b0011, 8'h40, "R5");
    step(4'b0011, 8'h80, "R5");
    step(4'b0011, 8'hff, "R5");

    // counter reset held then removed
    step(4'b1111, 8'hff, "R6");
    step(4'b1111, 8'h00, "R6");
    step(4'b0000, 8'h00, "R6");

    // R9: mode change invisible before the edge, data change immediate
    step(4'b0001, 8'h00, "R9");
    @(negedge clk);
    code = 4'b1111;
    #1;
    cmp("R9", outs(), {model(4'b0001, 8'h00), exp_ill});
    dat = 8'h08;
    #1;
    cmp("R9", outs(), {model(4'b0001, 8'h08), exp_ill});
    @(posedge clk);
    #1;
    cmp("R9", outs(), {model(4'b1111, 8'h08), exp_ill});

    // reserved codes and sticky flag
    step(4'b0111, 8'hff, "R7");
    step(4'b0100, 8'h02, "R8");
    step(4'b1011, 8'hff, "R7");
    step(4'b0011, 8'h40, "R8");
    do_reset();
    step(4'b1100, 8'h03, "R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] c;
      logic [7:0] d;
      c = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      step(c, d, req_of(c));
      if (i == 200) do_reset();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule